// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the bus clock. It supports two division laws, and a single mode input picks between them. Under the linear law the divider setting gives a serial clock period of an even number of bus clocks, two times the setting plus one. Under the power-of-two law the bus clock is divided by two raised to the setting plus one. Any setting above the largest power-of-two exponent is clamped to that exponent.

Besides the serial clock level, the block gives the shift engine two strobes, each one bus clock wide. One strobe marks each rising (leading) serial clock edge and the other marks each falling (trailing) edge. While the enable input is low the block is idle, with the serial clock parked low. Only during that idle time does it capture the mode and divider setting, so a setting cannot change while a transfer is under way. Software works out the setting for a target frequency.

Top module: `spi_sclk_divider`

## Requirements
- R1: During and right after reset, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: With `lin_mode` = 1, each half of the serial clock lasts `div_val`+1 bus clocks, so the period is 2×(`div_val`+1) for `div_val` 0 to 255. Setting 0 gives the fastest clock, half the bus clock.
- R3: With `lin_mode` = 0 and `div_val` from 0 to 15, each half lasts 2^`div_val` bus clocks, so the period is 2^(`div_val`+1).
- R4: With `lin_mode` = 0 and `div_val` above 15, the block behaves as for 15: each half lasts 32768 bus clocks.
- R5: The same `div_val` gives different periods under the two laws. For example, setting 3 gives a half of 4 clocks under the linear law and 8 clocks under the power-of-two law.
- R6: After `en` is first seen high at a rising bus clock edge, `sclk` stays low through that edge and the following half−1 edges. It rises at the half-th edge counted from that first one, with no earlier pulse.
- R7: `lead_stb` is 1 for exactly the one bus clock in which `sclk` has just risen, and `trail_stb` is 1 for exactly the one bus clock in which it has just fallen. The two are never 1 together.
- R8: At the first rising edge with `en` low, `sclk` goes low and neither strobe fires, even if `sclk` was high. When `en` is raised again, the timing restarts as in R6.
- R9: `lin_mode` and `div_val` are captured only at edges where `en` is low. Changes made while `en` is high have no effect on the period until the next disable. A change applied in the same cycle that `en` rises is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low parks the clock and opens the setting capture |
| lin_mode | input | 1 | 1 = linear even law, 0 = power-of-two law |
| div_val | input | 8 | Divider setting |
| sclk | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe on each rising serial clock edge |
| trail_stb | output | 1 | One-cycle strobe on each falling serial clock edge |

## Verification
Two pairs of events can land in the same cycle. The first pair is setting capture and enable rising. The bench raises `en` on the same falling edge that it changes `div_val` and `lin_mode`. It then counts bus clocks to the first rising serial edge, which must match the old setting. The second pair is a disable and a serial clock edge that would otherwise fall due. The bench drops `en` while `sclk` is high. It expects `sclk` low with no trailing strobe at the next sample, and then a clean restart of the first-edge timing when `en` is raised again.

// File: rtl/spi_div_pkg.sv
// Package spi_div_pkg
// Shared types and helpers for the serial clock divider.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package spi_div_pkg;

    // Division law selected by the mode input.
    typedef enum logic {
        LAW_POW2 = 1'b0,
        LAW_LIN  = 1'b1
    } div_law_e;

    // Larger of two widths, used to size the half-period counter.
    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_div_cfg.sv
// Module spi_div_cfg
// Captures the law and divider setting while the divider is idle.
// Turns them into a half-period length in bus clocks.
// Assumes: HALF_W can hold both 2^DIV_W and 2^EXP_MAX.
// The setting is frozen while en is high.
module spi_div_cfg
    import spi_div_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned EXP_MAX = 15,
    parameter int unsigned HALF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              lin_mode,
    input  logic [DIV_W-1:0]  div_val,
    output logic [HALF_W-1:0] half_q
);
    localparam int unsigned EXP_W = $clog2(EXP_MAX + 1);

    div_law_e          law;
    logic [EXP_W-1:0]  exp_sel;
    logic [HALF_W-1:0] half_lin;
    logic [HALF_W-1:0] half_pow;
    logic [HALF_W-1:0] half_d;

    // Clamp the exponent and evaluate both laws.
    always_comb begin
        law      = div_law_e'(lin_mode);
        exp_sel  = (div_val > DIV_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : EXP_W'(div_val);
        half_lin = HALF_W'(div_val) + HALF_W'(1);
        half_pow = HALF_W'(1) << exp_sel;
        half_d   = (law == LAW_LIN) ? half_lin : half_pow;
    end

    // Shadow register: loads only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_q <= HALF_W'(1);
        else if (!en)
            half_q <= half_d;
    end

    // R9: the half length is frozen across consecutive enabled cycles.
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(half_q));

    // R4: the half length never exceeds the larger of the two law maxima.
    a_r4_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q != '0) && (half_q <= HALF_W'(wmax(32'd1 << EXP_MAX, 32'd1 << DIV_W))));

endmodule

// File: rtl/spi_div_tick.sv
// Module spi_div_tick
// Counts bus clocks within one half of the serial clock.
// It flags the last clock of each half.
// Assumes: half_q is at least 1 and is held stable while en is high.
module spi_div_tick #(
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half_q,
    output logic              wrap
);
    logic [HALF_W-1:0] cnt_q;

    // Terminal count of the current half.
    always_comb begin
        wrap = en && (cnt_q == (half_q - HALF_W'(1)));
    end

    // Half-period counter; cleared while idle and at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + HALF_W'(1);
    end

    // R2: the counter always stays inside the current half.
    a_r2_cnt_in_half: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < half_q);

    // R8: the counter is cleared one clock after an idle cycle.
    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/spi_div_edge.sv
// Module spi_div_edge
// Holds the serial clock level and makes the leading and trailing strobes.
// Assumes: wrap is high for one clock at the end of each half, and only while en is high.
module spi_div_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wrap,
    output logic sclk_q,
    output logic lead_q,
    output logic trail_q
);
    // Toggle on wrap, park low while idle, and pulse the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sclk_q  <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            sclk_q  <= wrap ? !sclk_q : sclk_q;
            lead_q  <= wrap && !sclk_q;
            trail_q <= wrap && sclk_q;
        end
    end

    // R7: a leading strobe accompanies every rise of the serial clock.
    a_r7_lead_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> lead_q);

    // R7: a trailing strobe only when the level has just fallen.
    a_r7_trail_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        trail_q |-> (!sclk_q && $past(sclk_q)));

    // R7: strobes are mutually exclusive.
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lead_q, trail_q}) <= 1);

    // R8: an idle cycle parks the clock and suppresses both strobes.
    a_r8_idle_park: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk_q && !lead_q && !trail_q));

endmodule

// File: rtl/spi_sclk_divider.sv
// Module spi_sclk_divider (top)
// Serial clock divider with a linear even law and a power-of-two law.
// It gives the clock level and one-cycle edge strobes.
// Assumes: synchronous active-low reset, and settings that are driven
// from the bus clock domain.
module spi_sclk_divider
    import spi_div_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned EXP_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lin_mode,
    input  logic [DIV_W-1:0] div_val,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    localparam int unsigned HALF_W = wmax(DIV_W + 1, EXP_MAX + 1);

    logic [HALF_W-1:0] half_q;
    logic              wrap;

    spi_div_cfg #(
        .DIV_W   (DIV_W),
        .EXP_MAX (EXP_MAX),
        .HALF_W  (HALF_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .lin_mode (lin_mode),
        .div_val  (div_val),
        .half_q   (half_q)
    );

    spi_div_tick #(
        .HALF_W (HALF_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .half_q (half_q),
        .wrap   (wrap)
    );

    spi_div_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wrap    (wrap),
        .sclk_q  (sclk),
        .lead_q  (lead_stb),
        .trail_q (trail_stb)
    );

    // R1: outputs are quiet in the cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sclk && !lead_stb && !trail_stb));

endmodule

// File: tb/sim_spi_sclk_divider.sv
module sim_spi_sclk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       lin_mode = 1'b1;
    logic [7:0] div_val = 8'd0;
    logic       sclk, lead_stb, trail_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    spi_sclk_divider u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .lin_mode(lin_mode),
        .div_val(div_val), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling-edge samples until sclk reaches lvl.
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sclk !== lvl && n < 70000);
    endtask

    // Idle, load a setting, enable, and measure the first edge and the periods.
    task automatic run_setting(input bit lin, input int v, input int h,
                               input bit full, input string req);
        int n;
        @(negedge clk); en = 1'b0; lin_mode = lin; div_val = 8'(v);
        @(negedge clk);
        @(negedge clk); en = 1'b1;
        wait_level(1'b1, n);
        check(n == h, {req, " R6 first rise"}, n, h);
        check(lead_stb === 1'b1 && trail_stb === 1'b0, {req, " R7 lead strobe"}, int'(lead_stb), 1);
        if (full) begin
            wait_level(1'b0, n);
            check(n == h, {req, " high half"}, n, h);
            check(trail_stb === 1'b1 && lead_stb === 1'b0, {req, " R7 trail strobe"}, int'(trail_stb), 1);
            if (h > 1) begin
                @(negedge clk);
                check(trail_stb === 1'b0, {req, " R7 trail width"}, int'(trail_stb), 0);
                wait_level(1'b1, n);
                check(n == h - 1, {req, " low half"}, n, h - 1);
            end else begin
                wait_level(1'b1, n);
                check(n == h, {req, " low half"}, n, h);
            end
        end
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(sclk === 1'b0 && lead_stb === 1'b0 && trail_stb === 1'b0, "R1 reset", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk === 1'b0, "R1 after reset", int'(sclk), 0);
    endtask

    task automatic t_linear;
        run_setting(1'b1, 0, 1, 1'b1, "R2 lin v0");
        run_setting(1'b1, 3, 4, 1'b1, "R2 lin v3");
        run_setting(1'b1, 255, 256, 1'b1, "R2 lin v255");
    endtask

    task automatic t_expo;
        run_setting(1'b0, 0, 1, 1'b1, "R3 exp v0");
        run_setting(1'b0, 4, 16, 1'b1, "R3 exp v4");
        run_setting(1'b0, 3, 8, 1'b1, "R5 exp v3");
    endtask

    task automatic t_clamp;
        run_setting(1'b0, 200, 32768, 1'b0, "R4 exp clamp");
    endtask

    task automatic t_idle;
        int n;
        @(negedge clk); en = 1'b0; lin_mode = 1'b1; div_val = 8'd5;
        @(negedge clk);
        @(negedge clk); en = 1'b1;
        wait_level(1'b1, n);
        @(negedge clk); @(negedge clk); en = 1'b0;
        @(negedge clk);
        check(sclk === 1'b0, "R8 parked low", int'(sclk), 0);
        check(trail_stb === 1'b0 && lead_stb === 1'b0, "R8 no strobe", int'(trail_stb), 0);
        @(negedge clk); en = 1'b1;
        wait_level(1'b1, n);
        check(n == 6, "R8 restart first rise", n, 6);
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_hold;
        int n;
        @(negedge clk); en = 1'b0; lin_mode = 1'b1; div_val = 8'd2;
        @(negedge clk);
        @(negedge clk); en = 1'b1; lin_mode = 1'b0; div_val = 8'd9;
        wait_level(1'b1, n);
        check(n == 3, "R9 same-cycle change ignored", n, 3);
        wait_level(1'b0, n);
        check(n == 3, "R9 change while enabled ignored", n, 3);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        wait_level(1'b1, n);
        check(n == 512, "R9 new setting after disable", n, 512);
        @(negedge clk); en = 1'b0;
    endtask

    initial begin
        t_reset;
        t_linear;
        t_expo;
        t_clamp;
        t_idle;
        t_hold;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule